// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

One channel of a multi-channel timer controller. A down-counter is loaded from an initial-count register. It decrements once every (prescale + 1) clock cycles while enabled. When the count reaches zero the channel raises its pending flag. In periodic mode it then reloads from the initial count and keeps running. In one-shot mode it stops and clears its enable and active bits.

An interrupt line is driven high while the pending flag and the interrupt enable are both set. Software reaches the channel through a simple word-wide register port. Writes take effect at the rising clock edge. Reads are combinational from the selected register.

Register selection by `addr_i`: 0 = control, 1 = initial count, 2 = current count (read-only), 3 = status (bit 0 is this channel's pending flag).

Top module: `tmr_chan`

## Requirements
- R1: After reset the control register reads 0x00000005, and the initial-count, current-count and status registers read 0. `irq_o` is low.
- R2: Control register fields:
  - bit 30: enable
  - bit 29: interrupt enable
  - bit 27: periodic mode
  - bit 26: counter-reset command
  - bit 25: active (read-only)
  - bits 7:0: prescale

  Every other bit reads 0, and writes to those bits and to bit 25 are discarded.
- R3: A control write that sets both bit 26 and bit 30 discards the enable bit, so the channel ends up disabled.
- R4: Writing bit 26 as 1 reloads the current count from the initial count. Bit 26 always reads back 0.
- R5: While enabled, the current count decrements once every (prescale + 1) clock cycles. The first decrement comes (prescale + 1) cycles after the write that enabled the channel or reloaded the count.
- R6: The decrement that takes the count from 1 to 0 sets status bit 0. So does a decrement step taken at count 0. In periodic mode the count then reloads from the initial count and counting continues.
- R7: On that expiry in one-shot mode, the count rests at 0 and both the enable bit and the active bit clear.
- R8: `irq_o` is 1 exactly when the interrupt-enable bit and status bit 0 are both 1.
- R9: Writing status with bit 0 = 1 clears the pending flag. Writing bit 0 = 0 leaves it unchanged.
- R10: Writing the initial-count register reloads the current count with the new value at once, even while running.
- R11: When enable goes 0 to 1, the active bit sets and counting starts. When it goes 1 to 0, the active bit clears and the count freezes. A later enable resumes from the frozen value.
- R12: Writes to the current-count register have no effect.
- R13: A prescale change on a running channel leaves the current count unchanged. The new divide ratio applies from the next prescaler wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data of the selected register |
| irq_o | output | 1 | Channel interrupt |

## Verification
The most likely internal faults are these:
- a prescaler phase not cleared on restart
- an active prescale value latched at the wrong moment
- an enable flag that survives a one-shot expiry

Each of these shows on the current-count register within one prescale period, as a count one step early or late. It also shows as status bit 0 and `irq_o` rising a cycle off, or as a second expiry where none is due.

A pending flag that is mis-set or mis-cleared shows at `irq_o` in the very next cycle once interrupts are enabled. The directed tests therefore sample the count and the flag on the cycles either side of each expected transition.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CTRL_EN   = 30;
  localparam int unsigned CTRL_IE   = 29;
  localparam int unsigned CTRL_PER  = 27;
  localparam int unsigned CTRL_CRST = 26;
  localparam int unsigned CTRL_ACT  = 25;
  localparam int unsigned RST_PRE   = 5;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_INIT = 2'd1,
    REG_CNT  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic ie;
    logic per;
    logic act;
  } ctrl_flags_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] act_pre_q;  // ratio in force for the current period

  assign tick_o = run_i && !restart_i && (cnt_q == act_pre_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_pre_q <= '0;
    end else if (!run_i || restart_i || tick_o) begin
      cnt_q     <= '0;
      act_pre_q <= pre_i;
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign count_o  = cnt_q;
  assign expire_o = tick_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (reload_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i) begin
      if (expire_o) cnt_q <= periodic_i ? load_val_i : '0;
      else          cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_flags_t      flags_q;
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [CNT_W-1:0] init_q, count;
  logic             pend_q;
  logic             wr_ctrl, wr_init, wr_stat;
  logic             new_en, crst_cmd, reload, start, tick, expire;
  logic             en_q, act_q, per_q;

  assign en_q  = flags_q.en;
  assign act_q = flags_q.act;
  assign per_q = flags_q.per;

  assign wr_ctrl  = we_i && (reg_sel_e'(addr_i) == REG_CTRL);
  assign wr_init  = we_i && (reg_sel_e'(addr_i) == REG_INIT);
  assign wr_stat  = we_i && (reg_sel_e'(addr_i) == REG_STAT);

  // counter-reset overrides a simultaneous enable
  assign new_en   = wdata_i[CTRL_EN] && !wdata_i[CTRL_CRST];
  assign crst_cmd = wr_ctrl && wdata_i[CTRL_CRST];
  assign reload   = wr_init || crst_cmd;
  assign start    = wr_ctrl && new_en && !en_q;
  assign pre_nxt  = wr_ctrl ? wdata_i[PRE_W-1:0] : pre_q;

  tmr_prescaler #(.PRE_W(PRE_W)) i_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en_q),
    .restart_i (reload || start),
    .pre_i     (pre_nxt),
    .tick_o    (tick)
  );

  tmr_downcount #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (reload),
    .load_val_i (wr_init ? wdata_i[CNT_W-1:0] : init_q),
    .tick_i     (tick),
    .periodic_i (per_q),
    .count_o    (count),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      pre_q   <= PRE_W'(RST_PRE);
      init_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        flags_q.en  <= new_en;
        flags_q.act <= new_en;
        flags_q.ie  <= wdata_i[CTRL_IE];
        flags_q.per <= wdata_i[CTRL_PER];
        pre_q       <= wdata_i[PRE_W-1:0];
      end else if (expire && !per_q) begin
        flags_q.en  <= 1'b0;
        flags_q.act <= 1'b0;
      end
      if (wr_init) init_q <= wdata_i[CNT_W-1:0];
      // a new expiry wins over a same-cycle clear
      if (expire)                     pend_q <= 1'b1;
      else if (wr_stat && wdata_i[0]) pend_q <= 1'b0;
    end
  end

  assign irq_o = flags_q.ie && pend_q;

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      REG_CTRL: begin
        rdata_o[CTRL_EN]    = flags_q.en;
        rdata_o[CTRL_IE]    = flags_q.ie;
        rdata_o[CTRL_PER]   = flags_q.per;
        rdata_o[CTRL_ACT]   = flags_q.act;
        rdata_o[PRE_W-1:0]  = pre_q;
      end
      REG_INIT: rdata_o[CNT_W-1:0] = init_q;
      REG_CNT:  rdata_o[CNT_W-1:0] = count;
      REG_STAT: rdata_o[0]         = pend_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic             wcrst_i,
  input logic             irq_o,
  input logic             en_q,
  input logic             act_q,
  input logic             per_q,
  input logic             pend_q,
  input logic             expire,
  input logic             reload,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init_q
);
  p_crst_no_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == 2'd0 && wcrst_i |=> !en_q);

  p_pend_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> pend_q);

  p_periodic_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && per_q && !reload |=> count == init_q);

  p_oneshot_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && !per_q && !(we_i && addr_i == 2'd0) |=> !en_q && !act_q && count == '0);

  p_irq_needs_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_q);

  p_act_follows_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q == en_q);

  p_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !reload |=> $stable(count));

  p_cnt_ro_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == 2'd2 && !en_q |=> $stable(count));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wcrst_i (wdata_i[26]),
  .irq_o   (irq_o),
  .en_q    (en_q),
  .act_q   (act_q),
  .per_q   (per_q),
  .pend_q  (pend_q),
  .expire  (expire),
  .reload  (reload),
  .count   (count),
  .init_q  (init_q)
);

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
  localparam int unsigned DW = 32;
  localparam logic [1:0] A_CTRL = 2'd0, A_INIT = 2'd1, A_CNT = 2'd2, A_STAT = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int            n_chk = 0;
  int            n_bad = 0;

  always #5 clk = ~clk;

  tmr_chan i_tmr_chan (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_reg("R1 ctrl", A_CTRL, 32'h0000_0005);
    chk_reg("R1 init", A_INIT, 0);
    chk_reg("R1 count", A_CNT, 0);
    chk_reg("R1 stat", A_STAT, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_crst();
    wr(A_INIT, 7);
    wr(A_CTRL, 32'h4000_0000);
    idle(3);
    chk_reg("R5 count step", A_CNT, 4);
    wr(A_CTRL, 32'hFFFF_FFFF);
    chk_reg("R2 R3 R4 ctrl readback", A_CTRL, 32'h2800_00FF);
    chk_reg("R4 reload", A_CNT, 7);
    idle(5);
    chk_reg("R3 stays stopped", A_CNT, 7);
    chk("R3 irq", {31'b0, irq}, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_oneshot();
    wr(A_INIT, 10);
    wr(A_CTRL, 32'h6000_0000);
    chk_reg("R11 active set", A_CTRL, 32'h6200_0000);
    idle(9);
    chk_reg("R5 count before zero", A_CNT, 1);
    chk_reg("R6 no early pend", A_STAT, 0);
    idle(1);
    chk_reg("R6 pend", A_STAT, 1);
    chk("R8 irq", {31'b0, irq}, 1);
    chk_reg("R7 ctrl cleared", A_CTRL, 32'h2000_0000);
    chk_reg("R7 count zero", A_CNT, 0);
    wr(A_STAT, 0);
    chk_reg("R9 write 0 keeps", A_STAT, 1);
    wr(A_STAT, 1);
    chk_reg("R9 write 1 clears", A_STAT, 0);
    chk("R8 irq drop", {31'b0, irq}, 0);
  endtask

  task automatic t_periodic();
    wr(A_INIT, 4);
    wr(A_CTRL, 32'h4800_0003);
    idle(3);
    chk_reg("R5 hold inside period", A_CNT, 4);
    idle(1);
    chk_reg("R5 prescaled step", A_CNT, 3);
    idle(11);
    chk_reg("R6 no early pend", A_STAT, 0);
    idle(1);
    chk_reg("R6 periodic pend", A_STAT, 1);
    chk_reg("R6 periodic reload", A_CNT, 4);
    chk_reg("R6 still running", A_CTRL, 32'h4A00_0003);
    wr(A_STAT, 1);
    idle(14);
    chk_reg("R6 second period early", A_STAT, 0);
    idle(1);
    chk_reg("R6 second expiry", A_STAT, 1);
    wr(A_CTRL, 0);
    wr(A_STAT, 1);
  endtask

  task automatic t_freeze();
    wr(A_INIT, 50);
    wr(A_CTRL, 32'h4000_0000);
    idle(10);
    chk_reg("R5 running", A_CNT, 40);
    wr(A_CTRL, 0);
    chk_reg("R11 frozen value", A_CNT, 39);
    chk_reg("R11 active clear", A_CTRL, 0);
    idle(20);
    chk_reg("R11 still frozen", A_CNT, 39);
    wr(A_CTRL, 32'h4000_0000);
    idle(38);
    chk_reg("R11 resumed", A_CNT, 1);
    idle(1);
    chk_reg("R6 pend after resume", A_STAT, 1);
    chk("R8 masked irq", {31'b0, irq}, 0);
    chk_reg("R7 one-shot stop", A_CTRL, 0);
    wr(A_CTRL, 32'h2000_0000);
    chk("R8 irq on enable", {31'b0, irq}, 1);
    wr(A_STAT, 1);
    wr(A_CTRL, 0);
  endtask

  task automatic t_reload_and_ro();
    logic [DW-1:0] c;
    wr(A_INIT, 100);
    wr(A_CTRL, 32'h4000_0000);
    idle(5);
    chk_reg("R5 running", A_CNT, 95);
    wr(A_INIT, 20);
    chk_reg("R10 restart", A_CNT, 20);
    idle(5);
    chk_reg("R10 counting from new", A_CNT, 15);
    chk_reg("R10 init stored", A_INIT, 20);
    wr(A_CTRL, 0);
    rd(A_CNT, c);
    wr(A_CNT, 32'h0000_1234);
    chk_reg("R12 count write ignored", A_CNT, c);
    chk_reg("R12 init untouched", A_INIT, 20);
  endtask

  task automatic t_prescale_change();
    wr(A_INIT, 100);
    wr(A_CTRL, 32'h4000_0007);
    idle(1);
    wr(A_CTRL, 32'h4000_0000);
    chk_reg("R13 count kept", A_CNT, 100);
    idle(5);
    chk_reg("R13 old ratio holds", A_CNT, 100);
    idle(1);
    chk_reg("R13 wrap step", A_CNT, 99);
    idle(2);
    chk_reg("R13 new ratio", A_CNT, 97);
    wr(A_CTRL, 0);
  endtask

  initial begin
    #(10 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_crst();
    t_oneshot();
    t_periodic();
    t_freeze();
    t_reload_and_ro();
    t_prescale_change();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule